// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block sits behind the receive shift register of an I2C target and decides, after every start or repeated start, whether the device is being addressed. Each completed address byte from the shift register (seven address bits followed by the R/W bit in bit 0) is presented with a one-cycle `byte_valid` strobe. The byte is compared against three programmable address slots. Each slot can be enabled on its own and set to 7-bit or 10-bit format independently of the others. The byte is also compared against three fixed special addresses: general call, device ID and SMBus host.

A 10-bit address takes two bytes. The matcher remembers which slots accepted the header byte and finishes the compare on the second byte. For a 10-bit read, a later repeated start with a read header is accepted only for the slot that completed the preceding write header. When a match is found, the block reports the matched slot or special address and the transfer direction. It also raises a one-cycle ACK request together with a receive-full pulse (for a write) or a transmit-empty pulse (for a read). When nothing matches, the block requests no acknowledge and ignores the bus until the next start.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, `match`, `match_kind`, `rd`, `ack_req`, `rx_full` and `tx_empty` are 0. Address bytes that arrive before the first start are ignored.
- R2: A byte whose bits [7:1] equal `slotN_addr[6:0]` of an enabled 7-bit slot sets `match`. The block then reports `match_kind` = N+1, sets `rd` to bit 0 of the byte, and pulses `ack_req` for one cycle, starting the cycle after the byte.
- R3: A byte that matches no enabled slot and no enabled special address leaves `match` at 0 and `ack_req` at 0. The block then ignores further bytes until the next start.
- R4: An enabled 10-bit slot matches only after two bytes. The first byte is 11110, then `addr[9:8]`, then R/W=0. The second byte must equal `addr[7:0]`. Then `match_kind` = N+1 and `rd`=0. After the first byte alone, `match` stays 0.
- R5: After a repeated start, a header byte 11110, `addr[9:8]`, 1 is accepted, with `rd`=1, only for the slot that completed the write header in the transfer just before it. In any other case no match is reported.
- R6: When `gc_en` is set, the byte 0x00 matches as the general call, with `match_kind` = 4.
- R7: When `devid_en` is set, 7-bit address 0x7C (byte 0xF8 or 0xF9) matches as the device ID, with `match_kind` = 5 and `rd` taken from bit 0.
- R8: When `host_en` is set, 7-bit address 0x08 (byte 0x10 or 0x11) matches as the SMBus host, with `match_kind` = 6.
- R9: When several sources match, the lowest-numbered slot wins. Any slot wins over the special addresses, and among the special addresses general call wins over device ID, which wins over host.
- R10: On a write match, `rx_full` pulses together with `ack_req`. On a read match, `tx_empty` pulses together with `ack_req`. Each pulse lasts one cycle.
- R11: Once a match is reported, further bytes do not change `match`, `match_kind` or `rd`. A start clears `match` and `match_kind` on the next cycle.
- R12: 7-bit and 10-bit slots work at the same time, each in its own format.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_evt | input | 1 | Start or repeated start seen on the bus (one-cycle pulse) |
| byte_valid | input | 1 | `rx_byte` holds a completed address byte |
| rx_byte | input | 8 | Received byte, R/W in bit 0 |
| slot_en | input | 3 | Per-slot enable |
| slot_ten | input | 3 | Per-slot 10-bit format select |
| slot0_addr | input | 10 | Slot 0 address (7-bit format uses [6:0]) |
| slot1_addr | input | 10 | Slot 1 address |
| slot2_addr | input | 10 | Slot 2 address |
| gc_en | input | 1 | General call enable |
| devid_en | input | 1 | Device ID enable |
| host_en | input | 1 | SMBus host enable |
| match | output | 1 | Device addressed in this transfer |
| match_kind | output | 3 | 0 none, 1..3 slot 0..2, 4 general call, 5 device ID, 6 host |
| rd | output | 1 | Direction of the matched transfer, 1 = read |
| ack_req | output | 1 | One-cycle request to drive ACK |
| rx_full | output | 1 | One-cycle receive-full indication on a write match |
| tx_empty | output | 1 | One-cycle transmit-empty indication on a read match |

## Verification
The assertions assume that `byte_valid` and `start_evt` are single-cycle strobes that never rise together. They also assume that the slot configuration stays steady while an address phase is in progress. The bench drives every strobe for exactly one cycle, between falling edges. It changes the configuration only between transfers, before the start pulse. The ACK and indication pulses are therefore compared in the one cycle that follows each byte.

// File: rtl/i2c_addr_match.sv
module i2c_addr_match (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_evt,
  input  logic       byte_valid,
  input  logic [7:0] rx_byte,
  input  logic [2:0] slot_en,
  input  logic [2:0] slot_ten,
  input  logic [9:0] slot0_addr,
  input  logic [9:0] slot1_addr,
  input  logic [9:0] slot2_addr,
  input  logic       gc_en,
  input  logic       devid_en,
  input  logic       host_en,
  output logic       match,
  output logic [2:0] match_kind,
  output logic       rd,
  output logic       ack_req,
  output logic       rx_full,
  output logic       tx_empty
);
  typedef enum logic [1:0] {S_IDLE, S_FIRST, S_SECOND, S_DONE} st_t;

  st_t        state;
  logic [9:0] addr [3];
  logic [2:0] hit7, hdr, hit10, cand, own_mask;
  logic [2:0] own_kind, k1, k2;
  logic       own_valid, hit_q;
  logic       is_hdr;

  assign addr[0] = slot0_addr;
  assign addr[1] = slot1_addr;
  assign addr[2] = slot2_addr;
  assign is_hdr  = rx_byte[7:3] == 5'b11110;

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      hit7[i]  = slot_en[i] & ~slot_ten[i] & (rx_byte[7:1] == addr[i][6:0]);
      hdr[i]   = slot_en[i] & slot_ten[i] & is_hdr & (rx_byte[2:1] == addr[i][9:8]);
      hit10[i] = cand[i] & (rx_byte == addr[i][7:0]);
    end
  end

  always_comb begin
    k1 = 3'd0;
    if (hit7[0])                                       k1 = 3'd1;
    else if (hit7[1])                                  k1 = 3'd2;
    else if (hit7[2])                                  k1 = 3'd3;
    else if (rx_byte[0] && own_valid && |(hdr & own_mask)) k1 = own_kind;
    else if (gc_en && rx_byte == 8'h00)                k1 = 3'd4;
    else if (devid_en && rx_byte[7:1] == 7'h7C)        k1 = 3'd5;
    else if (host_en && rx_byte[7:1] == 7'h08)         k1 = 3'd6;
  end

  always_comb begin
    k2 = 3'd0;
    if (hit10[0])      k2 = 3'd1;
    else if (hit10[1]) k2 = 3'd2;
    else if (hit10[2]) k2 = 3'd3;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      match      <= 1'b0;
      match_kind <= 3'd0;
      rd         <= 1'b0;
      hit_q      <= 1'b0;
      cand       <= 3'd0;
      own_valid  <= 1'b0;
      own_mask   <= 3'd0;
      own_kind   <= 3'd0;
    end else if (start_evt) begin
      state      <= S_FIRST;
      match      <= 1'b0;
      match_kind <= 3'd0;
      rd         <= 1'b0;
      hit_q      <= 1'b0;
    end else begin
      hit_q <= 1'b0;
      if (byte_valid) begin
        case (state)
          S_FIRST: begin
            if (!(is_hdr && rx_byte[0])) own_valid <= 1'b0;
            if (k1 != 3'd0) begin
              match      <= 1'b1;
              match_kind <= k1;
              rd         <= rx_byte[0];
              hit_q      <= 1'b1;
              state      <= S_DONE;
            end else if (!rx_byte[0] && |hdr) begin
              cand  <= hdr;
              state <= S_SECOND;
            end else begin
              state <= S_DONE;
            end
          end
          S_SECOND: begin
            state <= S_DONE;
            if (k2 != 3'd0) begin
              match      <= 1'b1;
              match_kind <= k2;
              rd         <= 1'b0;
              hit_q      <= 1'b1;
              own_valid  <= 1'b1;
              own_kind   <= k2;
              own_mask   <= 3'b001 << (k2 - 3'd1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ack_req  = hit_q;
  assign rx_full  = hit_q & ~rd;
  assign tx_empty = hit_q & rd;

  assert_ack_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> $past(byte_valid));
  assert_ack_with_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> match);
  assert_read_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (rd && $rose(match)));
  assert_match_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !start_evt) |=> (match && $stable(match_kind) && $stable(rd)));
  assert_start_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (!match && match_kind == 3'd0));
endmodule

// File: tb/i2c_addr_match_tb.sv
module i2c_addr_match_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_evt = 1'b0, byte_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [2:0] slot_en, slot_ten;
  logic [9:0] slot0_addr, slot1_addr, slot2_addr;
  logic       gc_en, devid_en, host_en;
  logic       match, rd, ack_req, rx_full, tx_empty;
  logic [2:0] match_kind;
  int         n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  i2c_addr_match u_dut (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .byte_valid(byte_valid),
    .rx_byte(rx_byte), .slot_en(slot_en), .slot_ten(slot_ten),
    .slot0_addr(slot0_addr), .slot1_addr(slot1_addr), .slot2_addr(slot2_addr),
    .gc_en(gc_en), .devid_en(devid_en), .host_en(host_en),
    .match(match), .match_kind(match_kind), .rd(rd), .ack_req(ack_req),
    .rx_full(rx_full), .tx_empty(tx_empty));

  // {first byte, two-byte, second byte, exp match, exp kind, exp rd}
  localparam logic [21:0] VEC [12] = '{
    {8'h74, 1'b0, 8'h00, 1'b1, 3'd1, 1'b0},  // R2 slot0 write
    {8'h75, 1'b0, 8'h00, 1'b1, 3'd1, 1'b1},  // R2 slot0 read
    {8'h76, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0},  // R3 miss
    {8'hF4, 1'b1, 8'hC5, 1'b1, 3'd2, 1'b0},  // R4 slot1 10-bit
    {8'hF4, 1'b1, 8'hC6, 1'b0, 3'd0, 1'b0},  // R4 low byte miss
    {8'hF2, 1'b1, 8'hF0, 1'b1, 3'd3, 1'b0},  // R12 slot2 10-bit
    {8'h00, 1'b0, 8'h00, 1'b1, 3'd4, 1'b0},  // R6 general call
    {8'hF8, 1'b0, 8'h00, 1'b1, 3'd5, 1'b0},  // R7 device ID
    {8'hF9, 1'b0, 8'h00, 1'b1, 3'd5, 1'b1},  // R7 device ID read
    {8'h10, 1'b0, 8'h00, 1'b1, 3'd6, 1'b0},  // R8 host
    {8'h12, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0},  // R3 miss
    {8'hF5, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0}   // R5 read header with no prior write
  };

  task automatic check(input int act, input int exp, input string what);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk) start_evt = 1'b1;
    @(negedge clk) start_evt = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk) begin byte_valid = 1'b1; rx_byte = b; end
    @(negedge clk) byte_valid = 1'b0;
  endtask

  task automatic expect_hit(input int m, input int k, input int r, input string tag);
    check(match, m, {tag, " match"});
    check(match_kind, k, {tag, " kind"});
    if (m != 0) check(rd, r, {tag, " rd"});
    check(ack_req, m, {tag, " ack_req"});
    check(rx_full, (m != 0 && r == 0) ? 1 : 0, {tag, " rx_full"});
    check(tx_empty, (m != 0 && r != 0) ? 1 : 0, {tag, " tx_empty"});
  endtask

  initial begin
    #(20ns * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    slot_en = 3'b111; slot_ten = 3'b110;
    slot0_addr = 10'h03A; slot1_addr = 10'h2C5; slot2_addr = 10'h1F0;
    gc_en = 1'b1; devid_en = 1'b1; host_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(match, 0, "R1 reset match");
    check(match_kind, 0, "R1 reset kind");
    check(ack_req, 0, "R1 reset ack");
    send(8'h74);
    check(match, 0, "R1 byte before start ignored");
    check(ack_req, 0, "R1 no ack before start");

    for (int i = 0; i < 12; i++) begin
      do_start();
      send(VEC[i][21:14]);
      if (VEC[i][13]) begin
        check(match, 0, "R4 no match after header only");
        send(VEC[i][12:5]);
      end
      expect_hit(VEC[i][4], VEC[i][3:1], VEC[i][0], $sformatf("vec%0d", i));
      @(negedge clk);
      check(ack_req, 0, "R10 ack one cycle");
    end

    // R5: 10-bit read after matching write header
    do_start(); send(8'hF4); send(8'hC5);
    expect_hit(1, 2, 0, "R5 write header");
    do_start(); send(8'hF5);
    expect_hit(1, 2, 1, "R5 read accepted");
    // R5: read header for another slot is rejected
    do_start(); send(8'hF4); send(8'hC5);
    do_start(); send(8'hF3);
    expect_hit(0, 0, 0, "R5 other slot rejected");

    // R11: bytes after a match do not change it, start clears
    do_start(); send(8'h74);
    send(8'h11);
    check(match, 1, "R11 match held");
    check(match_kind, 1, "R11 kind held");
    check(rd, 0, "R11 rd held");
    check(ack_req, 0, "R11 no second ack");
    do_start();
    check(match, 0, "R11 start clears match");
    check(match_kind, 0, "R11 start clears kind");

    // R3: after a miss, later bytes are ignored
    do_start(); send(8'h40); send(8'h74);
    expect_hit(0, 0, 0, "R3 ignored after miss");

    // R9: lowest slot wins
    slot_ten = 3'b000; slot2_addr = 10'h03A;
    do_start(); send(8'h74);
    expect_hit(1, 1, 0, "R9 slot0 over slot2");
    slot_en = 3'b110;
    do_start(); send(8'h74);
    expect_hit(1, 3, 0, "R9 slot2 when slot0 off");
    // R9: slot beats special address
    slot_en = 3'b001; slot0_addr = 10'h008;
    do_start(); send(8'h10);
    expect_hit(1, 1, 0, "R9 slot over host");
    // R6/R7/R8 disabled specials do not match
    slot_en = 3'b000; gc_en = 1'b0; devid_en = 1'b0; host_en = 1'b0;
    do_start(); send(8'h00);
    expect_hit(0, 0, 0, "R6 general call disabled");
    do_start(); send(8'hF8);
    expect_hit(0, 0, 0, "R7 device ID disabled");
    do_start(); send(8'h10);
    expect_hit(0, 0, 0, "R8 host disabled");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule